// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives one external asynchronous memory space, such as a raw NAND flash with a byte-wide data bus. A client hands it one access at a time through a valid/ready request port. Each request carries a direction, an address and, for writes, a data byte. The block then produces the active-low chip-select, output-enable and write-enable strobes. It drives the address and write data, and it returns the byte captured during a read on a response port.

Each access runs through three timed phases: setup, strobe and hold. Reads and writes have separate programmable lengths for these phases, and every length is coded as the cycle count minus one. After a read, a programmable turnaround gap keeps the interface idle, so a slow memory output driver has released the bus before the next access begins. In NAND mode, two latch-enable outputs follow two low address bits: the command latch from bit 2 and the address latch from bit 1. The data path is fixed at 8 bits.

Top module: `amss_seq`

## Requirements
- R1: While reset is held and in the first cycles after it, chip select, output enable and write enable are high (inactive), data drive enable is low, both latch enables are low, ready is high and the response strobe is low.
- R2: A read keeps chip select low for (rs+1)+(rt+1)+(rh+1) cycles, where rs, rt and rh are the read setup, strobe and hold fields. Output enable goes low after rs+1 cycles of chip select and stays low for rt+1 cycles. A field of 0 gives a one-cycle phase.
- R3: A write uses the write setup, strobe and hold fields (ws, wt, wh) in the same way, with write enable in place of output enable. Output enable stays high during a write.
- R4: Output enable and write enable are never low together, and neither is ever low while chip select is high.
- R5: The read response byte equals the value on the data input in the last cycle of the strobe phase. The response strobe is a one-cycle pulse in the first hold cycle, which is the cycle in which output enable returns high.
- R6: During a write, the data drive enable is high and the latched write byte is on the data output for every cycle of chip select. At all other times, including during reads, the drive enable is low.
- R7: After a read, chip select stays high for turnaround+2 cycles before a waiting request starts (turnaround field 2 bits, cycles minus one, plus the one idle acceptance cycle). After a write, it stays high for exactly 1 cycle.
- R8: Ready is low from the cycle after acceptance until the block returns to idle, and it is low in every cycle in which chip select is low. The address, direction and write byte are latched at acceptance, so later changes on the request port have no effect on the access.
- R9: With NAND mode on, the command latch enable equals request address bit 2 and the address latch enable equals bit 1, held steady for the whole access. With NAND mode off, or between accesses, both are low. The memory address output equals the request address throughout the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Captured read byte |
| cfg_rd_setup | input | TW | Read setup length minus one |
| cfg_rd_strobe | input | TW | Read strobe length minus one |
| cfg_rd_hold | input | TW | Read hold length minus one |
| cfg_wr_setup | input | TW | Write setup length minus one |
| cfg_wr_strobe | input | TW | Write strobe length minus one |
| cfg_wr_hold | input | TW | Write hold length minus one |
| cfg_turn | input | TAW | Post-read idle gap minus one |
| cfg_nand | input | 1 | NAND latch-enable mode |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cle | output | 1 | Command latch enable |
| mem_ale | output | 1 | Address latch enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
Two events can fall in the same cycle. The first pair is the end of a read's turnaround gap and the acceptance of a request that has been held valid all through the previous access. The second pair is the read-data capture and the strobe-to-hold transition. The bench chains every access directly behind the previous one and counts the idle chip-select cycles against turnaround+2 or 1. Meanwhile, the memory model changes the read byte on every strobe cycle, so only a capture in the final strobe cycle returns the expected byte.

// File: rtl/amss_pkg.sv
package amss_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;
endpackage

// File: rtl/amss_phase_timer.sv
module amss_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          cnt_zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/amss_seq_ctl.sv
module amss_seq_ctl
  import amss_pkg::*;
#(
  parameter int TW  = 4,
  parameter int TAW = 2,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_wr,
  input  logic           cnt_zero,
  input  logic [TW-1:0]  rd_setup,
  input  logic [TW-1:0]  rd_strobe,
  input  logic [TW-1:0]  rd_hold,
  input  logic [TW-1:0]  wr_setup,
  input  logic [TW-1:0]  wr_strobe,
  input  logic [TW-1:0]  wr_hold,
  input  logic [TAW-1:0] turn,
  output phase_e         phase,
  output logic           is_wr,
  output logic           load,
  output logic [CW-1:0]  load_val
);
  phase_e phase_q, phase_d;
  logic   wr_q, wr_d;

  always_comb begin
    phase_d  = phase_q;
    wr_d     = wr_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d  = PH_SETUP;
        wr_d     = start_wr;
        load     = 1'b1;
        load_val = start_wr ? CW'(wr_setup) : CW'(rd_setup);
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d  = PH_STROBE;
        load     = 1'b1;
        load_val = wr_q ? CW'(wr_strobe) : CW'(rd_strobe);
      end
      PH_STROBE: if (cnt_zero) begin
        phase_d  = PH_HOLD;
        load     = 1'b1;
        load_val = wr_q ? CW'(wr_hold) : CW'(rd_hold);
      end
      PH_HOLD: if (cnt_zero) begin
        if (wr_q) begin
          phase_d = PH_IDLE;
        end else begin
          phase_d  = PH_TURN;
          load     = 1'b1;
          load_val = CW'(turn);
        end
      end
      PH_TURN: if (cnt_zero) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
    end
  end

  assign phase = phase_q;
  assign is_wr = wr_q;
endmodule

// File: rtl/amss_pin_ctl.sv
module amss_pin_ctl
  import amss_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CLE_BIT = 2,
  parameter int ALE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              nand_en,
  input  phase_e            phase,
  input  logic              is_wr,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              cle,
  output logic              ale,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              cle_q, ale_q, rsp_q;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
    end else if (start) begin
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
      cle_q   <= nand_en & start_addr[CLE_BIT];
      ale_q   <= nand_en & start_addr[ALE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= capture;
  end

  always_comb begin
    active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    cs_n   = !active;
    oe_n   = !((phase == PH_STROBE) && !is_wr);
    we_n   = !((phase == PH_STROBE) && is_wr);
    dq_oe  = active && is_wr;
    cle    = active && cle_q;
    ale    = active && ale_q;
  end

  assign addr      = addr_q;
  assign dq_out    = wdata_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/amss_seq.sv
module amss_seq
  import amss_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int TW      = 4,
  parameter int TAW     = 2,
  parameter int CLE_BIT = 2,
  parameter int ALE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [TW-1:0]     cfg_rd_setup,
  input  logic [TW-1:0]     cfg_rd_strobe,
  input  logic [TW-1:0]     cfg_rd_hold,
  input  logic [TW-1:0]     cfg_wr_setup,
  input  logic [TW-1:0]     cfg_wr_strobe,
  input  logic [TW-1:0]     cfg_wr_hold,
  input  logic [TAW-1:0]    cfg_turn,
  input  logic              cfg_nand,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_cle,
  output logic              mem_ale,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int CW = (TW > TAW) ? TW : TAW;

  phase_e        phase;
  logic          is_wr, load, cnt_zero, start, capture;
  logic [CW-1:0] load_val;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign capture   = (phase == PH_STROBE) && cnt_zero && !is_wr;

  amss_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .cnt_zero(cnt_zero)
  );

  amss_seq_ctl #(.TW(TW), .TAW(TAW), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(req_write), .cnt_zero(cnt_zero),
    .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
    .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
    .turn(cfg_turn), .phase(phase), .is_wr(is_wr), .load(load), .load_val(load_val)
  );

  amss_pin_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT)) u_pins (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(req_addr), .start_wdata(req_wdata),
    .nand_en(cfg_nand), .phase(phase), .is_wr(is_wr), .capture(capture), .dq_in(mem_dq_in),
    .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .cle(mem_cle), .ale(mem_ale),
    .addr(mem_addr), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/amss_seq_chk.sv
module amss_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_cs_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_cle,
  input logic mem_ale,
  input logic mem_dq_oe
);
  // R4: the two strobes are mutually exclusive
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R4: a strobe only inside chip select
  a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  // R6: bus driven only inside chip select and never with output enable low
  a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

  // R5: response appears as output enable returns high
  a_r5_rsp_at_oe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_oe_n));

  // R8: busy right after acceptance
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: never ready during an access
  a_r8_no_ready_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  // R9: latch enables steady across consecutive chip-select cycles
  a_r9_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_cle) && $stable(mem_ale)));
endmodule

bind amss_seq amss_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_cle(mem_cle), .mem_ale(mem_ale), .mem_dq_oe(mem_dq_oe)
);

// File: tb/amss_seq_bench.sv
`timescale 1ns/1ps
module amss_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [3:0]  rs, rt, rh, ws, wt, wh;
  logic [1:0]  ta;
  logic        nand_on;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_cle, mem_ale, mem_dq_oe;
  logic [15:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] oe_cnt;
  bit   first_acc = 1'b1;
  bit   last_wr;
  int   last_ta;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  amss_seq u_amss_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_rd_setup(rs), .cfg_rd_strobe(rt), .cfg_rd_hold(rh),
    .cfg_wr_setup(ws), .cfg_wr_strobe(wt), .cfg_wr_hold(wh),
    .cfg_turn(ta), .cfg_nand(nand_on),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_cle(mem_cle), .mem_ale(mem_ale), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // memory model: read byte changes on every strobe cycle
  always @(negedge clk) begin
    if (!mem_cs_n && !mem_oe_n) begin
      mem_dq_in <= (mem_addr[7:0] ^ 8'h5C) ^ oe_cnt;
      oe_cnt    <= oe_cnt + 8'd1;
    end else begin
      mem_dq_in <= 8'hA5;
      oe_cnt    <= 8'd0;
    end
  end

  // scoreboard monitor (R5)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected response", 1, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R5 read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d);
    int s, t, h, g, n, st_start, st_len, rsp_at, bad_kind, bad_dq, bad_lat, bad_rdy;
    logic ecle, eale;
    s = wr ? int'(ws) : int'(rs);
    t = wr ? int'(wt) : int'(rt);
    h = wr ? int'(wh) : int'(rh);
    ecle = nand_on & a[2];
    eale = nand_on & a[1];
    if (!wr) exp_q.push_back((a[7:0] ^ 8'h5C) ^ 8'(t));
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    g = 0;
    forever begin
      @(negedge clk);
      if (!mem_cs_n) break;
      g++;
    end
    if (!first_acc) chk("R7 idle gap", g + 1, last_wr ? 1 : last_ta + 2);
    // R8: change the port payload; the access must keep the latched values
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    n = 0; st_start = -1; st_len = 0; rsp_at = -1;
    bad_kind = 0; bad_dq = 0; bad_lat = 0; bad_rdy = 0;
    while (!mem_cs_n) begin
      if (!mem_oe_n || !mem_we_n) begin
        if (st_start < 0) st_start = n;
        st_len++;
        if (wr ? (!mem_oe_n || mem_we_n) : (!mem_we_n || mem_oe_n)) bad_kind++;
      end
      if (mem_dq_oe !== wr || (wr && mem_dq_out !== d)) bad_dq++;
      if (mem_cle !== ecle || mem_ale !== eale || mem_addr !== a) bad_lat++;
      if (req_ready !== 1'b0) bad_rdy++;
      if (rsp_valid) rsp_at = n;
      n++;
      @(negedge clk);
    end
    chk(wr ? "R3 cs length" : "R2 cs length", n, s + t + h + 3);
    chk(wr ? "R3 strobe start" : "R2 strobe start", st_start, s + 1);
    chk(wr ? "R3 strobe length" : "R2 strobe length", st_len, t + 1);
    chk("R4 strobe kind", bad_kind, 0);
    chk("R6 data drive in access", bad_dq, 0);
    chk("R9 latch and address", bad_lat, 0);
    chk("R8 ready low in access", bad_rdy, 0);
    chk("R5 response cycle", rsp_at, wr ? -1 : s + t + 2);
    chk("R6 drive off after access", int'(mem_dq_oe), 0);
    chk("R9 latches off after access", int'({mem_cle, mem_ale}), 0);
    first_acc = 1'b0;
    last_wr = wr;
    last_ta = int'(ta);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rs = 4'd2; rt = 4'd3; rh = 4'd1; ws = 4'd0; wt = 4'd5; wh = 4'd1; ta = 2'd1;
    nand_on = 1'b0; mem_dq_in = 8'hA5; oe_cnt = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1 strobes idle in reset", int'({mem_cs_n, mem_oe_n, mem_we_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes idle", int'({mem_cs_n, mem_oe_n, mem_we_n}), 7);
    chk("R1 drive and latches off", int'({mem_dq_oe, mem_cle, mem_ale}), 0);
    chk("R1 ready high", int'(req_ready), 1);
    chk("R1 no response", int'(rsp_valid), 0);

    // distinct read and write timing sets (R2, R3)
    access(1'b0, 16'h0006, 8'h00);
    access(1'b1, 16'h1234, 8'h3C);
    access(1'b0, 16'h00F1, 8'h00);
    // all-zero fields: one-cycle phases, minimum gap
    rs = 4'd0; rt = 4'd0; rh = 4'd0; ws = 4'd0; wt = 4'd0; wh = 4'd0; ta = 2'd0;
    access(1'b0, 16'h0040, 8'h00);
    access(1'b1, 16'h0002, 8'hC3);
    access(1'b1, 16'h0004, 8'h99);
    access(1'b0, 16'h0007, 8'h00);
    // NAND mode, maximum read fields and turnaround (R9, R7)
    nand_on = 1'b1;
    rs = 4'd15; rt = 4'd15; rh = 4'd15; ws = 4'd1; wt = 4'd2; wh = 4'd3; ta = 2'd3;
    access(1'b1, 16'h0004, 8'h70);
    access(1'b1, 16'h0002, 8'h00);
    access(1'b0, 16'h0006, 8'h00);
    access(1'b0, 16'h0000, 8'h00);
    access(1'b1, 16'hFFF9, 8'h5A);

    repeat (10) @(negedge clk);
    chk("R5 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule